// File: doc/BRIEF.md
# Scaled-Counter Multi-Channel PWM

This peripheral generates several pulse-width-modulated outputs from one shared free-running counter. The raw counter is shifted right by a programmable scale before it reaches the comparators. The period is therefore a power of two set by the scale field, and there is no separate period register. Each channel has its own 16-bit compare register and its own output pin. An output is high while the scaled count is at or above that channel's compare value. The pins have fixed inverted sense: a high pin is the inactive level. An optional zero-compare mode shortens the period by wrapping the counter once the scaled count reaches the value in compare register 0.

Software drives the block through a simple word-wide register bus with a write strobe and a combinational read port. Writes to the configuration, counter and compare registers take effect on the next clock, with no end-of-period shadowing. A period can therefore mix a new scale with an old compare value.

The counter is controlled by a two-state machine. In `ST_HOLD` the count is frozen. In `ST_RUN` it increments on every clock. The transition START (HOLD to RUN) is taken on the first clock edge at which the enable bit is set. The transition STOP (RUN to HOLD) is taken on the first edge at which the enable bit is clear. Counting uses the registered state, so the first increment comes one clock after the state machine enters RUN.

Top module: `pwm_scaled`

## Requirements
- R1: After reset, every register reads zero and all outputs are high, because a scaled count of 0 is at or above a compare value of 0.
- R2: Register map by byte address:
  - 0x00 is the configuration register. Only bits [3:0] (scale), 8, 9, 10, 12, 13, 16, 24 and 28 are stored; every other bit reads 0.
  - 0x08 is the 32-bit raw counter.
  - 0x10 is the scaled count.
  - 0x20 + 4*i is the compare register of channel i. It stores 16 bits and the upper bits read 0.
  - Any other address reads 0 and ignores writes.
- R3: The scaled count is the low 16 bits of (raw counter >> scale), zero-extended to 32 bits when read.
- R4: Output i is high exactly when the scaled count is greater than or equal to compare register i. A compare value of 0 keeps the output high.
- R5: When the scaled count is 0xFFFF, every output is high whatever its compare value, so no setting holds an output low for a whole period.
- R6: In ST_RUN the counter increments by one on each clock and wraps from 0xFFFFFFFF to 0.
- R7: In ST_HOLD the counter keeps its value. A bus write to 0x08 loads the counter on the next clock in either state, taking priority over the increment.
- R8: With configuration bit 9 (zero-compare) set, the counter returns to 0 on the clock after the last raw value whose scaled count equals compare register 0. The period becomes (cmp0+1) << scale clocks.
- R9: Writes to the scale or to a compare register change the outputs on the very next clock, with no wait for the end of a period.
- R10: The state machine enters ST_RUN on the clock edge after configuration bit 12 (enable) is set. It returns to ST_HOLD on the edge after the bit is cleared. The counter advances only on edges at which the registered state is ST_RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | Channel outputs, inverted sense |

## Verification
The hardest situation to reach is a zero-compare wrap at a scale above zero. The wrap needs the scaled count to equal compare register 0 and every bit shifted out of the raw count to be one, on the same clock. The stimulus presets the counter to 0 with the state machine in ST_HOLD, loads compare register 0 with 3 and then enables counting at scale 1. Twenty-four consecutive count samples must then stay at or below 7 and repeat every 8 clocks. The scaled-truncation and 0xFFFF cases are reached by presetting the raw counter while counting is stopped, so each comparator sees an exact scaled value.

// File: rtl/pwm_scaled_pkg.sv
package pwm_scaled_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADR_CFG  = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_SCL  = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_CMP0 = 8'h20;
    localparam int               CMP_STRIDE = 4;

    localparam int BIT_ZCMP = 9;
    localparam int BIT_EN   = 12;

    // stored configuration bits: scale, sticky, zero-compare, deglitch,
    // enable, enable-once, center, gang, pending
    localparam logic [DATA_W-1:0] CFG_KEEP = 32'h1101_370F;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_scaled_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_zcmp,
    input  logic [SCALE_W-1:0] cfg_scale,
    input  logic [CMP_W-1:0]   cmp0,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CMP_W-1:0]   scaled
);

    cnt_state_e        state_q;
    cnt_state_e        state_d;
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W-1:0]  low_mask;
    logic              at_end;

    always_comb begin
        scaled   = CMP_W'(cnt_q >> cfg_scale);
        low_mask = ~({CNT_W{1'b1}} << cfg_scale);
        at_end   = cfg_zcmp && (scaled == cmp0) && ((cnt_q & low_mask) == low_mask);
    end

    // next state: START when enable set, STOP when cleared
    always_comb begin
        unique case (state_q)
            ST_HOLD: state_d = cfg_en ? ST_RUN  : ST_HOLD;
            ST_RUN:  state_d = cfg_en ? ST_RUN  : ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // output process: counter update per state
    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else begin
            unique case (state_q)
                ST_HOLD: cnt_d = cnt_q;
                ST_RUN:  cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cnt_wr) |=> $stable(cnt_q));

    // R6
    run_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !cnt_wr && !cfg_zcmp) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R8
    zero_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !cnt_wr && cfg_zcmp && scaled == cmp0 && (&(cnt_q | ~low_mask)))
        |=> (cnt_q == '0));

    // R10
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cfg_en) |=> (state_q == ST_RUN));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int NCH   = 4,
    parameter int CMP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CMP_W-1:0]     scaled,
    input  logic [NCH*CMP_W-1:0] cmp_flat,
    output logic [NCH-1:0]       pwm_out
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CMP_W-1:0] thr;
        assign thr        = cmp_flat[i*CMP_W +: CMP_W];
        assign pwm_out[i] = (scaled >= thr);

        // R4
        zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr == '0) |-> pwm_out[i]);
    end

    // R5
    top_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&scaled) |-> (&pwm_out));

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_scaled_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 32,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [CNT_W-1:0]     cnt_q,
    input  logic [CMP_W-1:0]     scaled,
    output logic                 cfg_en,
    output logic                 cfg_zcmp,
    output logic [SCALE_W-1:0]   cfg_scale,
    output logic                 cnt_wr,
    output logic [NCH*CMP_W-1:0] cmp_flat
);

    logic [DATA_W-1:0] cfg_q;
    logic [NCH-1:0]    cmp_hit;

    assign cfg_en    = cfg_q[BIT_EN];
    assign cfg_zcmp  = cfg_q[BIT_ZCMP];
    assign cfg_scale = cfg_q[SCALE_W-1:0];
    assign cnt_wr    = bus_we && (bus_addr == ADR_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (bus_we && bus_addr == ADR_CFG) cfg_q <= bus_wdata & CFG_KEEP;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        logic [CMP_W-1:0] cmp_q;
        assign cmp_hit[i] = (bus_addr == ADR_CMP0 + ADDR_W'(CMP_STRIDE * i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cmp_q <= '0;
            else if (bus_we && cmp_hit[i]) cmp_q <= bus_wdata[CMP_W-1:0];
        end
        assign cmp_flat[i*CMP_W +: CMP_W] = cmp_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CFG) bus_rdata = cfg_q;
        if (bus_addr == ADR_CNT) bus_rdata = DATA_W'(cnt_q);
        if (bus_addr == ADR_SCL) bus_rdata = DATA_W'(scaled);
        for (int i = 0; i < NCH; i++) begin
            if (cmp_hit[i]) bus_rdata = DATA_W'(cmp_flat[i*CMP_W +: CMP_W]);
        end
    end

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_CFG) |=> (cfg_q == ($past(bus_wdata) & CFG_KEEP)));

endmodule

// File: rtl/pwm_scaled.sv
module pwm_scaled
    import pwm_scaled_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 32,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    logic                 cfg_en;
    logic                 cfg_zcmp;
    logic [SCALE_W-1:0]   cfg_scale;
    logic                 cnt_wr;
    logic [NCH*CMP_W-1:0] cmp_flat;
    logic [CNT_W-1:0]     cnt_q;
    logic [CMP_W-1:0]     scaled;

    pwm_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_q(cnt_q), .scaled(scaled),
        .cfg_en(cfg_en), .cfg_zcmp(cfg_zcmp), .cfg_scale(cfg_scale),
        .cnt_wr(cnt_wr), .cmp_flat(cmp_flat)
    );

    pwm_counter #(
        .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_zcmp(cfg_zcmp), .cfg_scale(cfg_scale),
        .cmp0(cmp_flat[CMP_W-1:0]),
        .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata[CNT_W-1:0]),
        .cnt_q(cnt_q), .scaled(scaled)
    );

    pwm_compare #(
        .NCH(NCH), .CMP_W(CMP_W)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .scaled(scaled), .cmp_flat(cmp_flat),
        .pwm_out(pwm_out)
    );

endmodule

// File: tb/pwm_scaled_tb.sv
module pwm_scaled_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_scaled u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // {scale, count, channel, compare, expected scaled, expected output}
    localparam logic [70:0] VEC [0:7] = '{
        {4'd0,  32'h0000_1234, 2'd0, 16'h1234, 16'h1234, 1'b1},
        {4'd0,  32'h0000_1233, 2'd1, 16'h1234, 16'h1233, 1'b0},
        {4'd4,  32'h0001_2340, 2'd2, 16'h1234, 16'h1234, 1'b1},
        {4'd4,  32'h0001_233F, 2'd3, 16'h1234, 16'h1233, 1'b0},
        {4'd15, 32'h8000_0000, 2'd0, 16'h0001, 16'h0000, 1'b0},
        {4'd15, 32'h7FFF_8000, 2'd1, 16'hFFFF, 16'hFFFF, 1'b1},
        {4'd8,  32'h00AB_CDEF, 2'd2, 16'hABCE, 16'hABCD, 1'b0},
        {4'd8,  32'h00AB_CDEF, 2'd3, 16'h0000, 16'hABCD, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c1, c2;
        logic [31:0] smp [0:23];
        logic [31:0] mx;
        bit per_ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 cfg", v, 0);
        rd(8'h08, v); check("R1 cnt", v, 0);
        rd(8'h10, v); check("R1 scaled", v, 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'h20 + 8'(4*i), v); check("R1 cmp", v, 0);
        end
        check("R1 outputs", {28'd0, pwm_out}, 32'hF);

        // R2 stored bits, unmapped address
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R2 cfg mask", v, 32'h1101_370F);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hDEAD_BEEF);
        rd(8'h04, v); check("R2 unmapped", v, 0);
        wr(8'h24, 32'hABCD_1234);
        rd(8'h24, v); check("R2 cmp width", v, 32'h0000_1234);

        // R3 R4 R5 vector table, counter held
        for (int k = 0; k < 8; k++) begin
            logic [3:0]  sc;
            logic [31:0] cn;
            logic [1:0]  ch;
            logic [15:0] cp, es;
            logic        eo;
            {sc, cn, ch, cp, es, eo} = VEC[k];
            wr(8'h00, {28'd0, sc});
            wr(8'h08, cn);
            wr(8'h20 + 8'(4*ch), {16'd0, cp});
            rd(8'h08, v);  check("R7 preset", v, cn);
            rd(8'h10, v);  check("R3 scaled", v, {16'd0, es});
            check("R4 R5 output", {31'd0, pwm_out[ch]}, {31'd0, eo});
        end

        // R9 no shadowing
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h100);
        wr(8'h24, 32'h100);
        check("R9 before", {31'd0, pwm_out[1]}, 1);
        wr(8'h24, 32'h101);
        check("R9 cmp immediate", {31'd0, pwm_out[1]}, 0);
        wr(8'h00, 32'h1);
        rd(8'h10, v); check("R9 scale immediate", v, 32'h80);

        // R10 start latency, R6 increment
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h1000);
        rd(8'h08, v); check("R10 after write", v, 0);
        @(negedge clk);
        rd(8'h08, v); check("R10 entering run", v, 0);
        @(negedge clk);
        rd(8'h08, c1); check("R10 first count", c1, 1);
        repeat (10) @(negedge clk);
        rd(8'h08, c2); check("R6 increment", c2 - c1, 10);

        // R7 write priority while running, R6 wrap
        wr(8'h08, 32'hFFFF_FFFE);
        rd(8'h08, v); check("R7 priority", v, 32'hFFFF_FFFE);
        repeat (2) @(negedge clk);
        rd(8'h08, v); check("R6 wrap", v, 0);

        // R7 hold after stop (STOP takes effect one edge later)
        wr(8'h00, 32'h0);
        repeat (2) @(negedge clk);
        rd(8'h08, c1);
        repeat (10) @(negedge clk);
        rd(8'h08, c2); check("R7 hold", c2, c1);

        // R8 zero-compare, scale 1, cmp0 = 3 -> period 8
        wr(8'h20, 32'h3);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h0000_1201);
        mx = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            rd(8'h08, smp[i]);
            if (smp[i] > mx) mx = smp[i];
        end
        check("R8 max count", mx, 7);
        per_ok = 1'b1;
        for (int i = 0; i < 16; i++) if (smp[i] != smp[i+8]) per_ok = 1'b0;
        check("R8 period", {31'd0, per_ok}, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule